// File: doc/BRIEF.md
# Page Load Window Controller

This block runs the page-load phase of a flash array that is programmed one page at a time. A host presents byte-load cycles on an active-low load strobe that carries an address and a data byte. The first falling edge of the strobe while the controller is idle opens a load window. Each rising edge stores the byte in a 128-entry page buffer at the offset given by the low seven address bits. It also records the upper address bits as the selected page.

A gap counter measures how long the strobe stays high after each load. A new falling edge before the limit keeps the window open, and the window can stay open for any number of loads. When the strobe stays high for the full limit, the window closes and a one-cycle start strobe is issued. The controller then stays busy for a fixed write-cycle time. During the first 128 busy cycles it streams the whole page to the array, one byte per cycle, in ascending offset order. A bitmap of loaded offsets substitutes FFh for every byte that was not loaded in this window. Strobes seen while busy are dropped.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `loading`, `busy`, `wr_start` and `prog_we` are all low.
- R2: A falling edge of `ld_n` while neither loading nor busy makes `loading` high from the following cycle until the window closes.
- R3: On each rising edge of `ld_n` inside the window, `ld_data` is stored at buffer offset `ld_addr[6:0]`, and `page_sel` takes `ld_addr[15:7]`.
- R4: The window closes when `ld_n` stays high for LOAD_GAP_CYC clock edges after the edge that captured the last rise. A falling edge sampled at or before the LOAD_GAP_CYC-th such edge keeps the window open, with no limit on the number of loads.
- R5: `busy` is high for exactly PROG_CYC cycles, starting in the cycle in which `wr_start` is high.
- R6: `wr_start` is a single-cycle pulse, given only when a window closes.
- R7: In the first 128 busy cycles, `prog_we` is high and `prog_addr` = {selected page, offset} with the offset stepping 0, 1, … 127.
- R8: `prog_data` for an offset that was not loaded in the current window is FFh.
- R9: Loading an offset again in the same window overwrites it; the last value is programmed.
- R10: The programmed page is the page field of the last byte loaded, even if earlier loads named other pages.
- R11: Strobes during `busy` do not open a window, store data, or alter any later page. A new window starts with every offset unloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low byte-load strobe |
| ld_addr | input | 16 | Byte-load address: page in [15:7], offset in [6:0] |
| ld_data | input | 8 | Byte-load data |
| loading | output | 1 | Load window is open |
| page_sel | output | 9 | Page of the last byte loaded |
| wr_start | output | 1 | One-cycle pulse at window close |
| busy | output | 1 | Internal write cycle in progress |
| prog_we | output | 1 | Array byte write strobe |
| prog_addr | output | 16 | Array byte address |
| prog_data | output | 8 | Array byte data |

## Verification
The hardest case to reach from the ports is the edge of the gap limit. There, a falling strobe arrives on the last edge that still counts as inside the window. The stimulus spaces loads exactly LOAD_GAP_CYC cycles apart and checks at each intervening cycle that the window holds. It then measures the exact close cycle after the final load. A second hard case is a strobe that both falls and rises while busy. It is injected partway through the write cycle. The next window then loads a single byte, and the scoreboard expects FFh at the offset the ignored strobe named.

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int OFFS_W       = 7,
  parameter int LOAD_GAP_CYC = 25000,
  parameter int PROG_CYC     = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              loading,
  output logic [ADDR_W-OFFS_W-1:0] page_sel,
  output logic              wr_start,
  output logic              busy,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  localparam int PAGE_W     = ADDR_W - OFFS_W;
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int PROG_LEN   = (PROG_CYC < PAGE_BYTES) ? PAGE_BYTES : PROG_CYC;
  localparam int GAP_W      = $clog2(LOAD_GAP_CYC + 1);
  localparam int PRG_W      = $clog2(PROG_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                    state;
  logic                   ldn_q;
  logic [GAP_W-1:0]       gap_cnt;
  logic [PRG_W-1:0]       prg_cnt;
  logic [PAGE_W-1:0]      page_q;
  logic [PAGE_BYTES-1:0]  loaded;
  logic [DATA_W-1:0]      pbuf [PAGE_BYTES];
  logic                   start_q;

  wire fall     = ldn_q & ~ld_n;
  wire rise     = ~ldn_q & ld_n;
  wire take     = (state == S_LOAD) & rise;
  wire gap_done = (state == S_LOAD) & ld_n & ldn_q &
                  (gap_cnt == GAP_W'(LOAD_GAP_CYC - 1));
  wire prg_last = prg_cnt == PRG_W'(PROG_LEN - 1);
  wire [OFFS_W-1:0] rd_idx = prg_cnt[OFFS_W-1:0];
  wire [OFFS_W-1:0] wr_idx = ld_addr[OFFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ldn_q   <= 1'b1;
      gap_cnt <= '0;
      prg_cnt <= '0;
      page_q  <= '0;
      start_q <= 1'b0;
    end else begin
      ldn_q   <= ld_n;
      start_q <= gap_done;
      case (state)
        S_IDLE: if (fall) begin
          state   <= S_LOAD;
          gap_cnt <= '0;
        end
        S_LOAD: begin
          if (rise) begin
            gap_cnt <= '0;
            page_q  <= ld_addr[ADDR_W-1:OFFS_W];
          end else if (gap_done) begin
            state   <= S_PROG;
            prg_cnt <= '0;
          end else if (ld_n && ldn_q) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_PROG: begin
          if (prg_last) state <= S_IDLE;
          prg_cnt <= prg_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      loaded <= '0;
    else if (state == S_IDLE && fall)
      loaded <= '0;
    else if (take)
      loaded[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[wr_idx] <= ld_data;
  end

  assign loading   = state == S_LOAD;
  assign busy      = state == S_PROG;
  assign wr_start  = start_q;
  assign page_sel  = page_q;
  assign prog_we   = busy && (prg_cnt < PRG_W'(PAGE_BYTES));
  assign prog_addr = {page_q, rd_idx};
  assign prog_data = loaded[rd_idx] ? pbuf[rd_idx] : '1;

  // R2: a fall while idle opens the window
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !busy && ldn_q && !ld_n) |=> loading);

  // R3: page follows the byte just captured
  a_r3_page_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && ld_n && !ldn_q) |=> page_sel == $past(ld_addr[ADDR_W-1:OFFS_W]));

  // R5: the start pulse falls inside the busy period
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> busy);

  // R6: start is one cycle wide
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  // R7: array writes happen only while busy, in ascending order
  a_r7_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> busy);
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && $past(prog_we)) |->
      prog_addr[OFFS_W-1:0] == $past(prog_addr[OFFS_W-1:0]) + 1'b1);

  // R11: no window while busy, page held
  a_r11_busy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !loading);
  a_r11_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_sel));
endmodule

// File: tb/page_load_ctrl_bench.sv
module page_load_ctrl_bench;
  localparam int GAP = 40;
  localparam int PRG = 200;
  localparam int NB  = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_n = 1'b1;
  logic [15:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        loading, wr_start, busy, prog_we;
  logic [8:0]  page_sel;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data;

  always #4 clk = ~clk;

  page_load_ctrl #(.LOAD_GAP_CYC(GAP), .PROG_CYC(PRG)) u_page_load_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ld_addr(ld_addr), .ld_data(ld_data),
    .loading(loading), .page_sel(page_sel), .wr_start(wr_start), .busy(busy),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data));

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_data [NB];
  bit         m_set  [NB];
  logic [8:0] m_page;
  logic [24:0] exp_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && prog_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R11 unexpected array write", prog_addr, 0);
      end else begin
        logic [24:0] it;
        it = exp_q.pop_front();
        check(prog_addr == it[24:8], "R7/R10 array address", prog_addr, it[24:8]);
        check(prog_data == it[7:0], it[7:0] == 8'hFF ? "R8 fill or data" : "R9 data",
              prog_data, it[7:0]);
      end
    end
  end

  task automatic begin_page();
    for (int i = 0; i < NB; i++) m_set[i] = 0;
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] d, input int gap);
    ld_n = 1'b0; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_n = 1'b1;
    m_data[a[6:0]] = d; m_set[a[6:0]] = 1; m_page = a[15:7];
    @(negedge clk);
    check(loading == 1'b1, "R2 window open", loading, 1);
    check(page_sel == m_page, "R3 page follows load", page_sel, m_page);
    for (int i = 1; i < gap; i++) begin
      @(negedge clk);
      check(loading && !wr_start, "R4 window held", {loading, wr_start}, 2);
    end
  endtask

  task automatic close_page(input bit inject);
    int k, b;
    for (int i = 0; i < NB; i++)
      exp_q.push_back({m_page, i[6:0], m_set[i] ? m_data[i] : 8'hFF});
    k = 1;
    while (!wr_start && k < GAP + 20) begin
      @(negedge clk);
      k++;
    end
    check(k == GAP + 1, "R4 close timing", k, GAP + 1);
    b = 0;
    while (busy && b < PRG + 20) begin
      b++;
      if (b == 2) check(!wr_start, "R6 start pulse width", wr_start, 0);
      if (inject && b == 5) begin ld_n = 1'b0; ld_addr = 16'h0020; ld_data = 8'hEE; end
      if (inject && b == 8) ld_n = 1'b1;
      if (inject && b > 5) check(!loading, "R11 no window while busy", loading, 0);
      @(negedge clk);
    end
    check(b == PRG, "R5 busy length", b, PRG);
    check(exp_q.size() == 0, "R7 whole page written", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!loading && !busy && !wr_start && !prog_we, "R1 reset state",
          {loading, busy, wr_start, prog_we}, 0);

    begin_page();
    load(16'h0903, 8'hA5, 5);
    load(16'h0905, 8'h3C, 5);
    load(16'h097F, 8'h11, 5);
    load(16'h0900, 8'h00, 0);
    close_page(0);

    begin_page();
    load(16'h1203, 8'h01, GAP);
    load(16'h1203, 8'h02, GAP);
    load(16'hD2AA, 8'h77, 3);
    load(16'hD281, 8'h5E, 0);
    close_page(0);

    begin_page();
    for (int i = 0; i < 12; i++) load({9'h055, i[6:0]}, 8'(i * 3), GAP);
    load(16'h2A40, 8'hC3, 0);
    close_page(1);

    for (int i = 0; i < GAP + 10; i++) begin
      @(negedge clk);
      check(!loading && !busy, "R11 ignored strobe left idle", {loading, busy}, 0);
    end

    begin_page();
    load(16'h0010, 8'h5A, 0);
    close_page(0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule